// File: doc/BRIEF.md
# Bus Idle-Gap Controller

This block sits between the bus requester arbiter and the external memory bus sequencer. It decides how many idle bus cycles must separate the access that just ran from the one about to start. Each access comes with a descriptor: the target area, read or write, whether it is a single-address DMA transfer and in which direction, and whether the area uses a shared address/data (multiplexed) bus. The block remembers the previously accepted descriptor. When a new one arrives, it works out the gap from the pair, counts the gap down and then pulses a start strobe to the sequencer.

Each of seven areas has a 3-bit idle code, and single-address DMA has one more. These codes are written through a small write-only configuration port. Dual-address DMA transfers present themselves exactly like CPU accesses, with the single-address flag clear.

Top module: `bus_idle_ctrl`

## Requirements
- R1: After reset every idle code (areas 0 to 6 and DMA) holds code 7, so the first area switch waits 15 cycles. Out of reset `req_ready` is 1 and `access_start` is 0.
- R2: A 3-bit idle code maps to a gap of 0, 1, 2, 3, 4, 6, 8 or 15 cycles for codes 0 through 7 respectively.
- R3: When the new access targets a different area than the preceding one, the gap is taken from the idle code of the preceding access's area.
- R4: When the preceding access was a single-address DMA transfer in the device-to-memory direction (`req_single_dma`=1, `req_dev_to_mem`=1), the gap is taken from the DMA idle code, whether or not the area changes.
- R5: A single-address DMA transfer in the memory-to-device direction, and any access with `req_single_dma`=0 (CPU or dual-address DMA), takes its gap from the area code.
- R6: On a non-multiplexed preceding access to the same area (and not a DMA device-to-memory transfer), the gap is 0 whatever the settings.
- R7: When the preceding access was on a multiplexed area, the gap is at least one cycle, even if the selected code is 0. A same-area access after a multiplexed read waits exactly one cycle.
- R8: On a multiplexed area, a write followed by any access to the same area waits max(decoded area code, 1) cycles.
- R9: A descriptor is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then drops, `access_start` pulses for one cycle exactly gap+1 cycles after the accepting edge, and `req_ready` returns in the cycle after the pulse.
- R10: `req_valid` is ignored while `req_ready` is 0. Such a descriptor produces no start pulse and does not become the preceding access.
- R11: The first access after reset has no preceding access and starts with a gap of 0.
- R12: A write with `cfg_we`=1 stores `cfg_code` into slot `cfg_sel` (0 to 6 = area, 7 = DMA). It applies to every descriptor accepted after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Idle code write strobe |
| cfg_sel | input | 3 | Slot select: 0-6 area, 7 DMA |
| cfg_code | input | 3 | Idle code to store |
| req_valid | input | 1 | New access descriptor present |
| req_area | input | 3 | Target area of the new access (0-6) |
| req_write | input | 1 | 1 = write access |
| req_single_dma | input | 1 | 1 = single-address DMA transfer |
| req_dev_to_mem | input | 1 | DMA direction, 1 = device to memory |
| req_mpx | input | 1 | Target area uses a multiplexed address/data bus |
| req_ready | output | 1 | Block is idle-complete and accepts a descriptor |
| access_start | output | 1 | One-cycle strobe: the accepted access may begin |

## Verification
The assertions assume that `req_area` stays below 7 and that `cfg_sel` never exceeds 7. They also assume the multiplexed flag is a fixed property of each area, so it is the same for every access to a given area. The stimulus uses only areas 0 to 6, writes only the eight defined slots, and always presents the same multiplexed flag for a given area within each phase of the run. Descriptors offered while the block is busy are withdrawn well before the longest gap could end, so the bench knows exactly which descriptor is accepted.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam int IDLE_CODE_W = 3;
    localparam int IDLE_CNT_W  = 4;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_GO    = 2'd2
    } gap_state_e;

    // Non-linear code-to-cycles ladder; the top code gives the longest gap.
    function automatic logic [IDLE_CNT_W-1:0] idle_code_cycles(input logic [IDLE_CODE_W-1:0] code);
        logic [IDLE_CNT_W-1:0] cyc;
        case (code)
            3'd0:    cyc = 4'd0;
            3'd1:    cyc = 4'd1;
            3'd2:    cyc = 4'd2;
            3'd3:    cyc = 4'd3;
            3'd4:    cyc = 4'd4;
            3'd5:    cyc = 4'd6;
            3'd6:    cyc = 4'd8;
            default: cyc = 4'd15;
        endcase
        return cyc;
    endfunction

endpackage

// File: rtl/idle_cfg_regs.sv
module idle_cfg_regs #(
    parameter int NUM_SLOTS = 8,
    parameter int SEL_W     = 3,
    parameter int CODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] codes [NUM_SLOTS]
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [CODE_W-1:0] code_d, code_q;

        always_comb begin
            code_d = code_q;
            if (we && (sel == SEL_W'(i))) begin
                code_d = code_in;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= '1;
            end else begin
                code_q <= code_d;
            end
        end

        assign codes[i] = code_q;
    end

endmodule

// File: rtl/idle_gap_calc.sv
module idle_gap_calc
    import idle_pkg::*;
#(
    parameter int NUM_AREAS = 7,
    parameter int NUM_SLOTS = 8,
    parameter int SEL_W     = 3,
    parameter int CODE_W    = 3,
    parameter int CNT_W     = 4
) (
    input  logic [CODE_W-1:0] codes [NUM_SLOTS],
    input  logic              have_prev,
    input  logic [SEL_W-1:0]  prev_area,
    input  logic              prev_write,
    input  logic              prev_d2m,
    input  logic              prev_mpx,
    input  logic [SEL_W-1:0]  next_area,
    output logic [CNT_W-1:0]  gap
);

    localparam int DMA_SLOT = NUM_AREAS;

    logic [CODE_W-1:0] area_code;
    logic [CODE_W-1:0] sel_code;
    logic [CNT_W-1:0]  sel_cycles;
    logic [CNT_W-1:0]  raw_gap;
    logic              same_area;

    always_comb begin
        area_code  = (int'(prev_area) < NUM_AREAS) ? codes[prev_area] : '0;
        sel_code   = prev_d2m ? codes[DMA_SLOT] : area_code;
        sel_cycles = CNT_W'(idle_code_cycles(sel_code));
        same_area  = (prev_area == next_area);

        if (!have_prev) begin
            raw_gap = '0;
        end else if (prev_d2m) begin
            raw_gap = sel_cycles;
        end else if (!same_area) begin
            raw_gap = sel_cycles;
        end else if (prev_mpx && prev_write) begin
            raw_gap = sel_cycles;
        end else begin
            raw_gap = '0;
        end

        gap = raw_gap;
        if (have_prev && prev_mpx && (raw_gap == '0)) begin
            gap = CNT_W'(1);
        end
    end

endmodule

// File: rtl/idle_gap_seq.sv
module idle_gap_seq
    import idle_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_area,
    input  logic             req_write,
    input  logic             req_d2m,
    input  logic             req_mpx,
    input  logic [CNT_W-1:0] gap,
    output logic             have_prev,
    output logic [SEL_W-1:0] prev_area,
    output logic             prev_write,
    output logic             prev_d2m,
    output logic             prev_mpx,
    output logic             ready,
    output logic             start
);

    typedef struct packed {
        gap_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             have_prev;
        logic [SEL_W-1:0] area;
        logic             write;
        logic             d2m;
        logic             mpx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;

    always_comb begin
        seq_d  = seq_q;
        accept = req_valid && (seq_q.state == ST_READY);
        case (seq_q.state)
            ST_READY: begin
                if (accept) begin
                    seq_d.have_prev = 1'b1;
                    seq_d.area      = req_area;
                    seq_d.write     = req_write;
                    seq_d.d2m       = req_d2m;
                    seq_d.mpx       = req_mpx;
                    if (gap == '0) begin
                        seq_d.state = ST_GO;
                    end else begin
                        seq_d.state = ST_WAIT;
                        seq_d.cnt   = gap - CNT_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_GO;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                seq_d.state = ST_READY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_READY, cnt: '0, have_prev: 1'b0,
                       area: '0, write: 1'b0, d2m: 1'b0, mpx: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign have_prev  = seq_q.have_prev;
    assign prev_area  = seq_q.area;
    assign prev_write = seq_q.write;
    assign prev_d2m   = seq_q.d2m;
    assign prev_mpx   = seq_q.mpx;
    assign ready      = (seq_q.state == ST_READY);
    assign start      = (seq_q.state == ST_GO);

endmodule

// File: rtl/bus_idle_ctrl.sv
module bus_idle_ctrl
    import idle_pkg::*;
#(
    parameter int NUM_AREAS = 7,
    parameter int CODE_W    = IDLE_CODE_W,
    parameter int CNT_W     = IDLE_CNT_W,
    localparam int NUM_SLOTS = NUM_AREAS + 1,
    localparam int SEL_W     = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_area,
    input  logic              req_write,
    input  logic              req_single_dma,
    input  logic              req_dev_to_mem,
    input  logic              req_mpx,
    output logic              req_ready,
    output logic              access_start
);

    logic [CODE_W-1:0] codes [NUM_SLOTS];
    logic              have_prev;
    logic [SEL_W-1:0]  prev_area;
    logic              prev_write;
    logic              prev_d2m;
    logic              prev_mpx;
    logic [CNT_W-1:0]  gap;
    logic              req_d2m;

    assign req_d2m = req_single_dma && req_dev_to_mem;

    idle_cfg_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .SEL_W     (SEL_W),
        .CODE_W    (CODE_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .code_in (cfg_code),
        .codes   (codes)
    );

    idle_gap_calc #(
        .NUM_AREAS (NUM_AREAS),
        .NUM_SLOTS (NUM_SLOTS),
        .SEL_W     (SEL_W),
        .CODE_W    (CODE_W),
        .CNT_W     (CNT_W)
    ) i_calc (
        .codes      (codes),
        .have_prev  (have_prev),
        .prev_area  (prev_area),
        .prev_write (prev_write),
        .prev_d2m   (prev_d2m),
        .prev_mpx   (prev_mpx),
        .next_area  (req_area),
        .gap        (gap)
    );

    idle_gap_seq #(
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_area   (req_area),
        .req_write  (req_write),
        .req_d2m    (req_d2m),
        .req_mpx    (req_mpx),
        .gap        (gap),
        .have_prev  (have_prev),
        .prev_area  (prev_area),
        .prev_write (prev_write),
        .prev_d2m   (prev_d2m),
        .prev_mpx   (prev_mpx),
        .ready      (req_ready),
        .start      (access_start)
    );

endmodule

// File: rtl/bus_idle_ctrl_chk.sv
module bus_idle_ctrl_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEL_W-1:0] req_area,
    input logic             req_single_dma,
    input logic             req_dev_to_mem,
    input logic             req_mpx,
    input logic             req_ready,
    input logic             access_start
);

    logic             acc;
    logic             c_have_prev;
    logic [SEL_W-1:0] c_area;
    logic             c_mpx;
    logic             c_d2m;
    logic [5:0]       wait_cnt;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_have_prev <= 1'b0;
            c_area      <= '0;
            c_mpx       <= 1'b0;
            c_d2m       <= 1'b0;
            wait_cnt    <= '0;
        end else begin
            if (acc) begin
                c_have_prev <= 1'b1;
                c_area      <= req_area;
                c_mpx       <= req_mpx;
                c_d2m       <= req_single_dma && req_dev_to_mem;
                wait_cnt    <= '0;
            end else if (!req_ready && !access_start && (wait_cnt != 6'h3f)) begin
                wait_cnt <= wait_cnt + 6'd1;
            end
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        access_start |=> !access_start); // R9
    AST_START_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        access_start |-> !req_ready); // R9
    AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        access_start |=> req_ready); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R10
    AST_FIRST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !c_have_prev) |=> access_start); // R11
    AST_MPX_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && c_have_prev && c_mpx) |=> !access_start); // R7
    AST_SAME_AREA_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && c_have_prev && !c_mpx && !c_d2m && (c_area == req_area)) |=> access_start); // R6
    AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= 6'd15); // R2

endmodule

bind bus_idle_ctrl bus_idle_ctrl_chk #(.SEL_W(SEL_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_area       (req_area),
    .req_single_dma (req_single_dma),
    .req_dev_to_mem (req_dev_to_mem),
    .req_mpx        (req_mpx),
    .req_ready      (req_ready),
    .access_start   (access_start)
);

// File: tb/test_bus_idle_ctrl.sv
`timescale 1ns/1ps
module test_bus_idle_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [2:0] cfg_code = '0;
    logic       req_valid = 1'b0;
    logic [2:0] req_area = '0;
    logic       req_write = 1'b0;
    logic       req_single_dma = 1'b0;
    logic       req_dev_to_mem = 1'b0;
    logic       req_mpx = 1'b0;
    logic       req_ready;
    logic       access_start;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int acc_c = 0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_idle_ctrl i_bus_idle_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_code       (cfg_code),
        .req_valid      (req_valid),
        .req_area       (req_area),
        .req_write      (req_write),
        .req_single_dma (req_single_dma),
        .req_dev_to_mem (req_dev_to_mem),
        .req_mpx        (req_mpx),
        .req_ready      (req_ready),
        .access_start   (access_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic cfg(input int sel, input int code);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 3'(sel);
        cfg_code = 3'(code);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: offer one descriptor when ready and queue the expected gap.
    task automatic access(input int area, input bit wr, input bit single,
                          input bit d2m, input bit mpx, input int exp, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_area       = 3'(area);
        req_write      = wr;
        req_single_dma = single;
        req_dev_to_mem = d2m;
        req_mpx        = mpx;
        req_valid      = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: measure gap between accept and start, compare with queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (req_valid && req_ready) acc_c = cyc;
                if (access_start) begin
                    int measured;
                    measured = cyc - acc_c - 1;
                    check(!req_ready, "R9", "ready during start", int'(req_ready), 0);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10", "unexpected start pulse", 1, 0);
                    end else begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(measured == e, t, "gap cycles", measured, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(access_start == 1'b0, "R1", "start after reset", int'(access_start), 0);

        access(0, 0, 0, 0, 0, 0,  "R11");
        access(1, 0, 0, 0, 0, 15, "R1");

        for (int i = 0; i < 7; i++) cfg(i, i);
        cfg(7, 2);

        // Walk areas: gap from preceding area code (R2, R3)
        access(2, 0, 0, 0, 0, 1, "R2");
        access(3, 0, 0, 0, 0, 2, "R2");
        access(4, 0, 0, 0, 0, 3, "R2");
        access(5, 0, 0, 0, 0, 4, "R3");
        access(6, 0, 0, 0, 0, 6, "R2");
        access(0, 0, 0, 0, 0, 8, "R2");
        access(1, 0, 0, 0, 0, 0, "R3");

        // Non-multiplexed same area (R6)
        access(1, 0, 0, 0, 0, 0, "R6");
        access(1, 1, 0, 0, 0, 0, "R6");
        access(1, 0, 0, 0, 0, 0, "R6");

        // Multiplexed area 0 (R7, R8)
        access(0, 0, 0, 0, 1, 1, "R3");
        access(3, 0, 0, 0, 0, 1, "R7");
        access(0, 0, 0, 0, 1, 3, "R3");
        access(0, 0, 0, 0, 1, 1, "R7");
        access(0, 1, 0, 0, 1, 1, "R7");
        access(0, 0, 0, 0, 1, 1, "R8");
        access(4, 1, 0, 0, 1, 1, "R7");
        access(4, 0, 0, 0, 1, 4, "R8");

        // Single-address DMA (R4, R5)
        access(5, 1, 1, 1, 0, 4, "R3");
        access(5, 0, 0, 0, 0, 2, "R4");
        access(6, 0, 1, 0, 0, 6, "R5");
        access(0, 0, 0, 0, 0, 8, "R5");

        // Reprogram area 2 to the top code (R12)
        cfg(2, 7);
        access(2, 0, 0, 0, 0, 0,  "R12");
        access(3, 0, 0, 0, 0, 15, "R12");

        // Offer a descriptor while busy; it must be ignored (R10)
        req_area  = 3'd6;
        req_write = 1'b1;
        req_mpx   = 1'b1;
        req_valid = 1'b1;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_mpx   = 1'b0;
        access(3, 0, 0, 0, 0, 0, "R10");

        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending starts", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R9", "ready at end", int'(req_ready), 1);
        summary();
        $finish;
    end

endmodule